// File: doc/BRIEF.md
# Periodic Scheduling Data Bus

This block sits between several per-requestor delay stages and a single predictable resource whose worst-case service time per atom is known. A programmable down-counter produces a scheduling tick once per service cycle. On each tick an attached arbiter chooses at most one eligible requestor. That requestor's atom (direction, address, write data) is latched and presented to the resource on the following cycle. No scheduling decision is taken between ticks, so the resource sees at most one atom per programmed service cycle.

When an atom is granted, the index of the granting port is queued. Reads and writes use separate queues because the resource may complete reads and writes in either order relative to each other. Each response returned by the resource is steered to the port at the head of the queue that matches its direction, and that entry is then retired. A write acknowledgement that carries no data retires a write entry in the same way. A requestor is eligible only while the queue for its request direction has room. The arbiter is a small pluggable unit, chosen by a parameter as round-robin or fixed priority.

The scheduler control is a two-state machine. In `SCH_IDLE` no atom is on the resource port. In `SCH_ISSUE` the atom latched on the previous tick is driven to the resource for one cycle. Transition *grant*: on a tick with an eligible requestor, either state moves to `SCH_ISSUE`. Transition *quiet*: on any other cycle, either state moves to `SCH_IDLE`.

Top module: `sched_data_bus`

## Requirements
- R1: The first scheduling tick falls in the first cycle after reset is released. Every later tick follows the previous one by `cfg_period`+1 cycles, where `cfg_period` is the value in force when the counter reloaded.
- R2: On a tick at most one bit of `req_grant` is set, and no bit is set outside tick cycles. In the cycle after a grant, `res_cmd_valid` is 1 for one cycle and carries the granted port's write flag, address and write data.
- R3: With `ARB_POLICY`=0 (the default), grants rotate. After port i is granted, the search on the next tick starts at port i+1 (mod N), and port 0 has first turn after reset. With `ARB_POLICY`=1, the lowest-numbered eligible port wins.
- R4: On a tick with no eligible requestor, there is no grant, no resource command, and no entry is queued.
- R5: A requestor with `req_write`=0 (read) is eligible only while the read queue (depth `FIFO_DEPTH`) is not full. One with `req_write`=1 (write) is eligible only while the write queue is not full. A full queue of one direction does not block the other direction.
- R6: A response with `res_rsp_write`=0 sets only bit p of `rsp_valid`, where p is the head of the read queue. With `res_rsp_write`=1, p is the head of the write queue. The read and write queues are retired independently of each other, and `rsp_data` and `rsp_write` copy the resource response.
- R7: A new `cfg_period` value written at any point takes effect only at the next counter reload. The tick already counted down keeps the old spacing.
- R8: A write acknowledgement (`res_rsp_valid`=1, `res_rsp_write`=1) retires the head of the write queue, whatever its data.
- R9: A response whose direction queue is empty is dropped: `rsp_valid` stays all zero.
- R10: During reset, `req_grant`, `res_cmd_valid` and `rsp_valid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_period | input | CNT_W | Service-cycle length minus one |
| req_valid | input | N_PORTS | Atom present on port i |
| req_write | input | N_PORTS | Atom direction on port i (1 = write) |
| req_addr | input | N_PORTS*ADDR_W | Atom addresses, port i at bits i*ADDR_W |
| req_wdata | input | N_PORTS*DATA_W | Write data, port i at bits i*DATA_W |
| req_grant | output | N_PORTS | One-hot grant pulse in a tick cycle |
| res_cmd_valid | output | 1 | Atom presented to the resource |
| res_cmd_write | output | 1 | Direction of the presented atom |
| res_cmd_addr | output | ADDR_W | Address of the presented atom |
| res_cmd_wdata | output | DATA_W | Write data of the presented atom |
| res_rsp_valid | input | 1 | Resource returns a response |
| res_rsp_write | input | 1 | Response direction (1 = write acknowledgement) |
| res_rsp_data | input | DATA_W | Response data |
| rsp_valid | output | N_PORTS | One-hot routed response strobe |
| rsp_write | output | 1 | Direction of the routed response |
| rsp_data | output | DATA_W | Data of the routed response |

## Verification
Two events can fall in the same cycle. A grant can push an index into a queue while a response pops that same queue. And a response can arrive in the very cycle its command is on the resource port. Both are provoked by setting the service-cycle length to one cycle and answering every read command at once, so that each cycle both grants and retires on port 0. They are judged by requiring a grant on every tick and a response routed to port 0 in every command cycle. The period change is checked in the same run by comparing the observed tick cycles with a list computed from the reload rule.

// File: rtl/psb_pkg.sv
package psb_pkg;
    typedef enum logic [0:0] {
        SCH_IDLE  = 1'b0,
        SCH_ISSUE = 1'b1
    } sch_state_e;

    localparam int POL_ROUND_ROBIN = 0;
    localparam int POL_FIXED_PRIO  = 1;
endpackage

// File: rtl/psb_tick_gen.sv
module psb_tick_gen #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_period,
    output logic             tick
);
    logic [CNT_W-1:0] cnt_q;
    logic             tick_q;

    // reload from cfg_period only on expiry, so new values wait for the reload
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (cnt_q == '0) begin
            cnt_q  <= cfg_period;
            tick_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q - 1'b1;
            tick_q <= 1'b0;
        end
    end

    assign tick = tick_q;

    // R1: a nonzero loaded length never yields two ticks in a row
    a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && $past(cfg_period) != '0) |=> !tick);
endmodule

// File: rtl/psb_arbiter.sv
module psb_arbiter #(
    parameter int N      = 4,
    parameter int POLICY = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] elig,
    input  logic         take,
    output logic [N-1:0] gnt,
    output logic         found
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    generate
        if (POLICY == psb_pkg::POL_ROUND_ROBIN) begin : g_rr
            logic [IDX_W-1:0] ptr_q;
            logic [IDX_W-1:0] win;

            always_comb begin
                gnt   = '0;
                found = 1'b0;
                win   = ptr_q;
                for (int off = 1; off <= N; off++) begin
                    int idx;
                    idx = (int'(ptr_q) + off) % N;
                    if (!found && elig[idx]) begin
                        gnt[idx] = 1'b1;
                        found    = 1'b1;
                        win      = IDX_W'(idx);
                    end
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    ptr_q <= IDX_W'(N - 1);
                else if (take && found)
                    ptr_q <= win;
            end
        end else begin : g_fixed
            always_comb begin
                gnt   = '0;
                found = 1'b0;
                for (int i = 0; i < N; i++) begin
                    if (!found && elig[i]) begin
                        gnt[i] = 1'b1;
                        found  = 1'b1;
                    end
                end
            end
        end
    endgenerate

    // R3: the arbiter never names a port that was not eligible
    a_r3_grant_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~elig) == '0);
endmodule

// File: rtl/psb_id_fifo.sv
module psb_id_fifo #(
    parameter int W     = 2,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem_q [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [AW:0]   cnt_q;
    logic          do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == (AW+1)'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem_q[rp_q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push)
                wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            if (do_pop)
                rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            if (do_push && !do_pop)
                cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push)
            mem_q[wp_q] <= din;
    end

    // R5: the scheduler never offers an index to a full queue
    a_r5_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R9: the router never retires from an empty queue
    a_r9_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/sched_data_bus.sv
module sched_data_bus #(
    parameter int N_PORTS    = 4,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int CNT_W      = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int ARB_POLICY = 0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [CNT_W-1:0]            cfg_period,
    input  logic [N_PORTS-1:0]          req_valid,
    input  logic [N_PORTS-1:0]          req_write,
    input  logic [N_PORTS*ADDR_W-1:0]   req_addr,
    input  logic [N_PORTS*DATA_W-1:0]   req_wdata,
    output logic [N_PORTS-1:0]          req_grant,
    output logic                        res_cmd_valid,
    output logic                        res_cmd_write,
    output logic [ADDR_W-1:0]           res_cmd_addr,
    output logic [DATA_W-1:0]           res_cmd_wdata,
    input  logic                        res_rsp_valid,
    input  logic                        res_rsp_write,
    input  logic [DATA_W-1:0]           res_rsp_data,
    output logic [N_PORTS-1:0]          rsp_valid,
    output logic                        rsp_write,
    output logic [DATA_W-1:0]           rsp_data
);
    import psb_pkg::*;

    localparam int IDX_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;

    logic               tick;
    logic [N_PORTS-1:0] elig, gnt;
    logic               found, take;
    logic [IDX_W-1:0]   gidx;
    logic               rd_full, wr_full, rd_empty, wr_empty;
    logic [IDX_W-1:0]   rd_head, wr_head;
    logic               push_rd, push_wr, pop_rd, pop_wr;
    sch_state_e         state_q, state_d;
    logic               cmd_write_q;
    logic [ADDR_W-1:0]  cmd_addr_q;
    logic [DATA_W-1:0]  cmd_wdata_q;

    // ---------------- service-cycle tick ----------------
    psb_tick_gen #(.CNT_W(CNT_W)) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_period (cfg_period),
        .tick       (tick)
    );

    // ---------------- eligibility per port ----------------
    generate
        for (genvar p = 0; p < N_PORTS; p++) begin : g_elig
            assign elig[p] = req_valid[p] & (req_write[p] ? ~wr_full : ~rd_full);
        end
    endgenerate

    psb_arbiter #(.N(N_PORTS), .POLICY(ARB_POLICY)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .elig  (elig),
        .take  (take),
        .gnt   (gnt),
        .found (found)
    );

    assign take      = tick && found;
    assign req_grant = take ? gnt : '0;

    always_comb begin
        gidx = '0;
        for (int i = 0; i < N_PORTS; i++)
            if (gnt[i])
                gidx = IDX_W'(i);
    end

    assign push_rd = take && !req_write[gidx];
    assign push_wr = take &&  req_write[gidx];

    // ---------------- scheduler state machine ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= SCH_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SCH_IDLE:  state_d = take ? SCH_ISSUE : SCH_IDLE;
            SCH_ISSUE: state_d = take ? SCH_ISSUE : SCH_IDLE;
            default:   state_d = SCH_IDLE;
        endcase
    end

    always_comb begin
        res_cmd_valid = 1'b0;
        unique case (state_q)
            SCH_IDLE:  res_cmd_valid = 1'b0;
            SCH_ISSUE: res_cmd_valid = 1'b1;
            default:   res_cmd_valid = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_write_q <= 1'b0;
            cmd_addr_q  <= '0;
            cmd_wdata_q <= '0;
        end else if (take) begin
            cmd_write_q <= req_write[gidx];
            cmd_addr_q  <= req_addr[gidx*ADDR_W +: ADDR_W];
            cmd_wdata_q <= req_wdata[gidx*DATA_W +: DATA_W];
        end
    end

    assign res_cmd_write = cmd_write_q;
    assign res_cmd_addr  = cmd_addr_q;
    assign res_cmd_wdata = cmd_wdata_q;

    // ---------------- identifier queues per direction ----------------
    psb_id_fifo #(.W(IDX_W), .DEPTH(FIFO_DEPTH)) u_rd_ids (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_rd),
        .din   (gidx),
        .pop   (pop_rd),
        .dout  (rd_head),
        .empty (rd_empty),
        .full  (rd_full)
    );

    psb_id_fifo #(.W(IDX_W), .DEPTH(FIFO_DEPTH)) u_wr_ids (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_wr),
        .din   (gidx),
        .pop   (pop_wr),
        .dout  (wr_head),
        .empty (wr_empty),
        .full  (wr_full)
    );

    // ---------------- response routing ----------------
    assign pop_rd = res_rsp_valid && !res_rsp_write && !rd_empty;
    assign pop_wr = res_rsp_valid &&  res_rsp_write && !wr_empty;

    always_comb begin
        rsp_valid = '0;
        if (pop_rd)
            rsp_valid[rd_head] = 1'b1;
        else if (pop_wr)
            rsp_valid[wr_head] = 1'b1;
    end

    assign rsp_write = res_rsp_write;
    assign rsp_data  = res_rsp_data;

    // R2: one grant at most, and only on a tick
    a_r2_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_grant) && ((req_grant == '0) || tick));
    // R2: a grant is followed by exactly one command cycle
    a_r2_cmd_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_grant) |=> res_cmd_valid);
    // R4: no command without a grant in the cycle before
    a_r4_cmd_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        res_cmd_valid |-> $past(|req_grant));
    // R6: a response reaches at most one port
    a_r6_route_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_valid) && ((rsp_valid == '0) || res_rsp_valid));
endmodule

// File: tb/sched_data_bus_test.sv
`timescale 1ns/1ps
module sched_data_bus_test;
    localparam int N  = 4;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int CW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [CW-1:0]   cfg_period = 8'd3;
    logic [N-1:0]    req_valid = '0, req_write = '0;
    logic [N*AW-1:0] req_addr = '0;
    logic [N*DW-1:0] req_wdata = '0;
    logic [N-1:0]    req_grant;
    logic            res_cmd_valid, res_cmd_write;
    logic [AW-1:0]   res_cmd_addr;
    logic [DW-1:0]   res_cmd_wdata;
    logic            res_rsp_valid = 1'b0, res_rsp_write = 1'b0;
    logic [DW-1:0]   res_rsp_data = '0;
    logic [N-1:0]    rsp_valid;
    logic            rsp_write;
    logic [DW-1:0]   rsp_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sched_data_bus #(.N_PORTS(N), .ADDR_W(AW), .DATA_W(DW), .CNT_W(CW),
                     .FIFO_DEPTH(4), .ARB_POLICY(0)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_grant(req_grant),
        .res_cmd_valid(res_cmd_valid), .res_cmd_write(res_cmd_write),
        .res_cmd_addr(res_cmd_addr), .res_cmd_wdata(res_cmd_wdata),
        .res_rsp_valid(res_rsp_valid), .res_rsp_write(res_rsp_write),
        .res_rsp_data(res_rsp_data),
        .rsp_valid(rsp_valid), .rsp_write(rsp_write), .rsp_data(rsp_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic reset_idle_check();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(req_grant == '0, "R10", "grant in reset", int'(req_grant), 0);
        chk(res_cmd_valid == 1'b0, "R10", "cmd in reset", int'(res_cmd_valid), 0);
        chk(rsp_valid == '0, "R10", "rsp in reset", int'(rsp_valid), 0);
        rst_n = 1'b1;
    endtask

    // response drive at negedge, check combinational routing shortly after
    task automatic respond(input bit wr, input logic [DW-1:0] d,
                           input logic [N-1:0] exp_port, input string req);
        @(negedge clk);
        res_rsp_valid = 1'b1;
        res_rsp_write = wr;
        res_rsp_data  = d;
        #1;
        chk(rsp_valid == exp_port, req, "routed port", int'(rsp_valid), int'(exp_port));
        if (exp_port != '0) begin
            chk(rsp_data == d && rsp_write == wr, req, "routed payload",
                int'(rsp_data), int'(d));
        end
    endtask

    // R7 expected tick cycles: P=3 until reload at 9, then 1, then 0 from reload at 15
    function automatic bit tick_exp(input int n);
        return (n == 1) || (n == 5) || (n == 9) || (n == 11) || (n == 13) || (n >= 15);
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "WATCHDOG", "run hung", 0, 1);
        finish_run();
    end

    initial begin
        logic [N-1:0] prev_g;
        int granted;
        // ---- sweep 1: rotation, queue full, direction independence ----
        cfg_period = 8'd3;
        for (int i = 0; i < N; i++) begin
            req_addr[i*AW +: AW]  = AW'(8'h10 + i);
            req_wdata[i*DW +: DW] = DW'(16'hA000 + i);
        end
        req_valid = 4'b1111;
        req_write = 4'b0000;
        reset_idle_check();
        prev_g  = '0;
        granted = 0;
        for (int n = 1; n <= 30; n++) begin
            logic [N-1:0] exp_g;
            @(negedge clk);
            exp_g = '0;
            if ((n - 1) % 4 == 0) begin
                if (n <= 13) exp_g = N'(1) << ((n - 1) / 4);
                else if (n == 25) exp_g = 4'b0100;
            end
            if (n == 17 || n == 21)
                chk(req_grant == '0, "R5", "read blocked by full queue",
                    int'(req_grant), 0);
            else if (n == 25)
                chk(req_grant == exp_g, "R5", "write passes full read queue",
                    int'(req_grant), int'(exp_g));
            else if (n == 29)
                chk(req_grant == '0, "R4", "idle tick grants nothing",
                    int'(req_grant), 0);
            else
                chk(req_grant == exp_g, "R3", "rotation grant", int'(req_grant), int'(exp_g));
            chk(res_cmd_valid == (prev_g != '0), "R2", "cmd one cycle after grant",
                int'(res_cmd_valid), int'(prev_g != '0));
            if (prev_g != '0) begin
                int p;
                p = $clog2(int'(prev_g));
                chk(res_cmd_addr == AW'(8'h10 + p), "R2", "cmd address",
                    int'(res_cmd_addr), 16 + p);
                chk(res_cmd_write == (n == 26), "R2", "cmd direction",
                    int'(res_cmd_write), int'(n == 26));
                if (n == 26)
                    chk(res_cmd_wdata == 16'hBEEF, "R2", "cmd write data",
                        int'(res_cmd_wdata), 16'hBEEF);
            end
            if (exp_g != '0) granted++;
            prev_g = exp_g;
            if (n == 24) begin
                req_write[2] = 1'b1;
                req_wdata[2*DW +: DW] = 16'hBEEF;
            end
            if (n == 26) req_valid = '0;
        end
        chk(granted == 5, "R4", "grants in sweep", granted, 5);

        // ---- responses: read queue holds 0,1,2,3; write queue holds 2 ----
        respond(1'b1, 16'h0000, 4'b0100, "R8");
        respond(1'b0, 16'h1111, 4'b0001, "R6");
        respond(1'b0, 16'h2222, 4'b0010, "R6");
        respond(1'b1, 16'h0000, 4'b0000, "R9");
        respond(1'b0, 16'h3333, 4'b0100, "R6");
        respond(1'b0, 16'h4444, 4'b1000, "R6");
        respond(1'b0, 16'h5555, 4'b0000, "R9");
        @(negedge clk);
        res_rsp_valid = 1'b0;

        // ---- sweep 2: period change, push and pop in one cycle ----
        cfg_period = 8'd3;
        req_valid  = 4'b0001;
        req_write  = 4'b0000;
        reset_idle_check();
        for (int n = 1; n <= 22; n++) begin
            @(negedge clk);
            res_rsp_valid = res_cmd_valid;
            res_rsp_write = 1'b0;
            res_rsp_data  = DW'(n);
            if (n == 5)  cfg_period = 8'd1;
            if (n == 13) cfg_period = 8'd0;
            #1;
            chk(req_grant == (tick_exp(n) ? 4'b0001 : 4'b0000),
                (n >= 15) ? "R1" : "R7", "tick cycle",
                int'(req_grant), int'(tick_exp(n)));
            chk(rsp_valid == (res_cmd_valid ? 4'b0001 : 4'b0000), "R6",
                "same-cycle response", int'(rsp_valid), int'(res_cmd_valid));
        end
        @(negedge clk);
        res_rsp_valid = 1'b0;
        req_valid = '0;
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule